// File: doc/BRIEF.md
# Hashed Page Table Walker

This sequential block turns a 32-bit effective address into a real address by walking a hashed page table held in memory. The top four address bits pick one of sixteen segment registers inside the block, and that register supplies a 24-bit virtual segment ID. The walker hashes the segment ID with the page index and reads the eight entries of the primary group one after another. If none of them matches, it reads the eight entries of the secondary group, which is found from the complemented hash. On a hit it fetches the second word of the matching entry, sets the entry's referenced bit and, for stores, its changed bit. Each of these updates is a single-byte write. It then reports the real address, both entry words and the entry's address. Permission checks are not done here; a neighbouring unit makes them from the returned words.

Memory is reached through a word-read port and a byte-write port. Each port holds its request, with a stable address, until it sees an acknowledge. Only one request is outstanding at a time. The table base and the table mask are configuration inputs. The base is aligned down to 64 bytes. Software or a neighbouring block loads the segment registers through a single write port.

The controller has six states. IDLE waits for `start_i` and then goes to READ_TAG. READ_TAG reads the first word of the current entry. On an acknowledge it does one of four things:
- it goes to READ_DATA when the entry matches;
- it steps to the next entry;
- it moves from the last primary entry to the first secondary entry;
- it goes to FINISH after the last secondary entry.

READ_DATA reads the second word. From there it goes to SET_REF if the referenced bit is clear, to SET_CHG if only the changed bit needs setting on a store, and to FINISH otherwise. SET_REF goes to SET_CHG or to FINISH. SET_CHG goes to FINISH. FINISH lasts one cycle and returns to IDLE.

Top module: `hpt_walker`

## Requirements
- R1: After reset `busy_o`, `done_o`, `found_o`, `miss_o`, `rd_req_o` and `wr_req_o` are all low, and while `busy_o` is low no memory request is raised.
- R2: A `start_i` seen while idle raises `busy_o` at the next edge. `busy_o` stays high up to and including the single `done_o` cycle, then falls. A `start_i` pulse while busy is ignored and starts no second walk.
- R3: The hash is the segment ID XOR the page index (address bits 27..12, zero-extended). The primary group address is `(tbl_base_i & ~63) + ((hash << 6) & tbl_mask_i)`. Entry k of the group sits at group address + 8k. The first word is at +0 and the second word at +4, and every read address is word aligned.
- R4: For each entry the first word is read before any other access to that entry. The second word is read only for the entry whose first word matched.
- R5: A first word matches only when bit 31 (valid) is 1, bit 6 (hash select) equals 0 on the primary pass and 1 on the secondary pass, bits 30..7 equal the segment ID, and bits 5..0 equal address bits 27..22.
- R6: Entries are searched in order 0 to 7, and the first matching entry ends the search.
- R7: After eight primary misses the walker searches the secondary group. Its address is computed as in R3, but from the bitwise complement of the 32-bit zero-extended hash.
- R8: When all sixteen entries miss, `done_o` comes with `miss_o` high and `found_o` low. The walker makes exactly sixteen reads and no writes.
- R9: On a hit, `done_o` comes with `found_o` high. `real_addr_o` is the second word's bits 31..12 joined with address bits 11..0. `entry_w0_o` and `entry_w1_o` carry the two words, and `entry_addr_o` carries the entry address.
- R10: If the second word's bit 8 (referenced) is 0, the walker writes one byte to entry address + 6. The byte is the second word's bits 15..8 ORed with 0x01.
- R11: If bit 7 (changed) is 0 and the access is a store, the walker writes one byte to entry address + 7. The byte is the second word's bits 7..0 ORed with 0x80. This write comes after any referenced-bit write. Loads never write it.
- R12: The segment register is chosen by address bits 31..28. A write on the segment port takes effect at the next edge.
- R13: At most one of `rd_req_o` and `wr_req_o` is high. A request, with its address and byte, holds until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_wr_en_i | input | 1 | Segment register write strobe |
| seg_wr_idx_i | input | 4 | Segment register to write |
| seg_wr_vsid_i | input | 24 | Segment ID to store |
| tbl_base_i | input | 32 | Table base address (aligned down to 64 bytes) |
| tbl_mask_i | input | 32 | Mask applied to the group offset |
| start_i | input | 1 | Start a walk (taken only when idle) |
| ea_i | input | 32 | Effective address to translate |
| store_i | input | 1 | Access is a store |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| found_o | output | 1 | Hit, valid with done_o |
| miss_o | output | 1 | Both groups missed, valid with done_o |
| real_addr_o | output | 32 | Translated real address |
| entry_w0_o | output | 32 | First word of the matched entry |
| entry_w1_o | output | 32 | Second word of the matched entry |
| entry_addr_o | output | 32 | Address of the matched entry |
| rd_req_o | output | 1 | Word read request |
| rd_addr_o | output | 32 | Word read address |
| rd_ack_i | input | 1 | Read acknowledge, data valid |
| rd_data_i | input | 32 | Read data |
| wr_req_o | output | 1 | Byte write request |
| wr_addr_o | output | 32 | Byte write address |
| wr_byte_o | output | 8 | Byte to write |
| wr_ack_i | input | 1 | Write acknowledge |

## Verification
The assertions check the handshake rules on every cycle: a single outstanding port, and a request held stable until its acknowledge. They also check the busy and done framing of a walk, word alignment of reads, and the byte lane and set bit of each status write. Whether the walker visits the right addresses in the right order, matches the right entry and writes the right bytes depends on table contents. Only the bench's scenarios can show this, by comparing every read and write against a behavioural walk over its own memory. These scenarios cover skipped invalid and wrong-pass entries, first-match priority, the secondary fallback, a full miss, loads against stores, segment selection and a start pulse ignored while busy.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_TAG,
        ST_READ_DATA,
        ST_SET_REF,
        ST_SET_CHG,
        ST_FINISH
    } walk_state_t;

    // first-word field positions
    localparam int W0_VALID_BIT = 31;
    localparam int W0_HSEL_BIT  = 6;
    // second-word status bits
    localparam int W1_REF_BIT   = 8;
    localparam int W1_CHG_BIT   = 7;

    localparam logic [7:0] REF_SET_MASK = 8'h01;
    localparam logic [7:0] CHG_SET_MASK = 8'h80;

    localparam int DATA_WORD_OFF = 4;
    localparam int REF_BYTE_OFF  = 6;
    localparam int CHG_BYTE_OFF  = 7;

endpackage

// File: rtl/hpt_seg_file.sv
module hpt_seg_file #(
    parameter int SEG_BITS = 4,
    parameter int VSID_W   = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SEG_BITS-1:0] wr_idx,
    input  logic [VSID_W-1:0]   wr_vsid,
    input  logic [SEG_BITS-1:0] rd_idx,
    output logic [VSID_W-1:0]   rd_vsid
);
    localparam int NUM_SEGS = 1 << SEG_BITS;

    logic [VSID_W-1:0] seg_q [NUM_SEGS];

    // R12: one register per segment, written through the single port
    for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seg_q[g] <= '0;
            end else if (wr_en && (wr_idx == SEG_BITS'(g))) begin
                seg_q[g] <= wr_vsid;
            end
        end
    end

    assign rd_vsid = seg_q[rd_idx];

endmodule

// File: rtl/hpt_hash_unit.sv
module hpt_hash_unit #(
    parameter int ADDR_W    = 32,
    parameter int VSID_W    = 24,
    parameter int PIDX_W    = 16,
    parameter int API_W     = 6,
    parameter int GRP_SHIFT = 6
) (
    input  logic [VSID_W-1:0] vsid,
    input  logic [PIDX_W-1:0] pidx,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] mask,
    input  logic              sec,
    output logic [ADDR_W-1:0] group_addr,
    output logic [ADDR_W-1:0] tag
);
    localparam int PAD = ADDR_W - VSID_W;
    localparam logic [ADDR_W-1:0] ALIGN =
        {{(ADDR_W-GRP_SHIFT){1'b1}}, {GRP_SHIFT{1'b0}}};

    logic [VSID_W-1:0] hash;
    logic [ADDR_W-1:0] hash_ext;
    logic [ADDR_W-1:0] hash_sel;
    logic [ADDR_W-1:0] grp_off;

    // R3: XOR of segment ID and page index
    assign hash     = vsid ^ {{(VSID_W-PIDX_W){1'b0}}, pidx};
    assign hash_ext = {{PAD{1'b0}}, hash};
    // R7: secondary pass uses the complemented hash
    assign hash_sel = sec ? ~hash_ext : hash_ext;
    assign grp_off  = (hash_sel << GRP_SHIFT) & mask;

    assign group_addr = (base & ALIGN) + grp_off;

    // R5: compare value, valid and hash-select positions left zero
    assign tag = {1'b0, vsid, 1'b0, pidx[PIDX_W-1 -: API_W]};

endmodule

// File: rtl/hpt_entry_cmp.sv
module hpt_entry_cmp #(
    parameter int WORD_W    = 32,
    parameter int VALID_BIT = 31,
    parameter int HSEL_BIT  = 6
) (
    input  logic [WORD_W-1:0] word,
    input  logic [WORD_W-1:0] tag,
    input  logic              sec,
    output logic              match
);
    localparam logic [WORD_W-1:0] CMP_MASK =
        ~((WORD_W'(1) << VALID_BIT) | (WORD_W'(1) << HSEL_BIT));

    // R5: valid, pass select and abbreviated page index
    assign match = word[VALID_BIT]
                && (word[HSEL_BIT] == sec)
                && ((word & CMP_MASK) == (tag & CMP_MASK));

endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int VSID_W        = 24,
    parameter int SEG_BITS      = 4,
    parameter int PAGE_BITS     = 12,
    parameter int GROUP_ENTRIES = 8,
    parameter int ENTRY_BYTES   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                seg_wr_en_i,
    input  logic [SEG_BITS-1:0] seg_wr_idx_i,
    input  logic [VSID_W-1:0]   seg_wr_vsid_i,
    input  logic [ADDR_W-1:0]   tbl_base_i,
    input  logic [ADDR_W-1:0]   tbl_mask_i,
    input  logic                start_i,
    input  logic [ADDR_W-1:0]   ea_i,
    input  logic                store_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                found_o,
    output logic                miss_o,
    output logic [ADDR_W-1:0]   real_addr_o,
    output logic [ADDR_W-1:0]   entry_w0_o,
    output logic [ADDR_W-1:0]   entry_w1_o,
    output logic [ADDR_W-1:0]   entry_addr_o,
    output logic                rd_req_o,
    output logic [ADDR_W-1:0]   rd_addr_o,
    input  logic                rd_ack_i,
    input  logic [ADDR_W-1:0]   rd_data_i,
    output logic                wr_req_o,
    output logic [ADDR_W-1:0]   wr_addr_o,
    output logic [7:0]          wr_byte_o,
    input  logic                wr_ack_i
);
    localparam int PIDX_W      = ADDR_W - SEG_BITS - PAGE_BITS;
    localparam int API_W       = ADDR_W - VSID_W - 2;
    localparam int IDX_W       = $clog2(GROUP_ENTRIES);
    localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);
    localparam int GRP_SHIFT   = IDX_W + ENTRY_SHIFT;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUP_ENTRIES - 1);

    walk_state_t st_q, st_n;

    logic [VSID_W-1:0]    vsid_q;
    logic [PIDX_W-1:0]    pidx_q;
    logic [PAGE_BITS-1:0] off_q;
    logic                 store_q;
    logic                 sec_q;
    logic [IDX_W-1:0]     idx_q;
    logic                 hit_q;
    logic [ADDR_W-1:0]    w0_q;
    logic [ADDR_W-1:0]    w1_q;

    logic [VSID_W-1:0]    seg_vsid;
    logic [ADDR_W-1:0]    group_addr;
    logic [ADDR_W-1:0]    tag;
    logic [ADDR_W-1:0]    entry_addr;
    logic                 tag_match;

    // ------------------------------------------------------------------
    // sub-blocks
    // ------------------------------------------------------------------
    hpt_seg_file #(
        .SEG_BITS (SEG_BITS),
        .VSID_W   (VSID_W)
    ) u_seg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (seg_wr_en_i),
        .wr_idx  (seg_wr_idx_i),
        .wr_vsid (seg_wr_vsid_i),
        .rd_idx  (ea_i[ADDR_W-1 -: SEG_BITS]),
        .rd_vsid (seg_vsid)
    );

    hpt_hash_unit #(
        .ADDR_W    (ADDR_W),
        .VSID_W    (VSID_W),
        .PIDX_W    (PIDX_W),
        .API_W     (API_W),
        .GRP_SHIFT (GRP_SHIFT)
    ) u_hash (
        .vsid       (vsid_q),
        .pidx       (pidx_q),
        .base       (tbl_base_i),
        .mask       (tbl_mask_i),
        .sec        (sec_q),
        .group_addr (group_addr),
        .tag        (tag)
    );

    hpt_entry_cmp #(
        .WORD_W    (ADDR_W),
        .VALID_BIT (W0_VALID_BIT),
        .HSEL_BIT  (W0_HSEL_BIT)
    ) u_cmp (
        .word  (rd_data_i),
        .tag   (tag),
        .sec   (sec_q),
        .match (tag_match)
    );

    assign entry_addr = group_addr + (ADDR_W'(idx_q) << ENTRY_SHIFT);

    // ------------------------------------------------------------------
    // state register
    // ------------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_n;
    end

    // ------------------------------------------------------------------
    // next state
    // ------------------------------------------------------------------
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i) st_n = ST_READ_TAG;
            end
            ST_READ_TAG: begin
                if (rd_ack_i) begin
                    if (tag_match)                    st_n = ST_READ_DATA;
                    else if (idx_q == LAST_IDX && sec_q) st_n = ST_FINISH;
                end
            end
            ST_READ_DATA: begin
                if (rd_ack_i) begin
                    if (!rd_data_i[W1_REF_BIT])                   st_n = ST_SET_REF;
                    else if (store_q && !rd_data_i[W1_CHG_BIT])   st_n = ST_SET_CHG;
                    else                                          st_n = ST_FINISH;
                end
            end
            ST_SET_REF: begin
                if (wr_ack_i) begin
                    if (store_q && !w1_q[W1_CHG_BIT]) st_n = ST_SET_CHG;
                    else                              st_n = ST_FINISH;
                end
            end
            ST_SET_CHG: begin
                if (wr_ack_i) st_n = ST_FINISH;
            end
            ST_FINISH: st_n = ST_IDLE;
            default:   st_n = ST_IDLE;
        endcase
    end

    // ------------------------------------------------------------------
    // walk context
    // ------------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vsid_q  <= '0;
            pidx_q  <= '0;
            off_q   <= '0;
            store_q <= 1'b0;
            sec_q   <= 1'b0;
            idx_q   <= '0;
            hit_q   <= 1'b0;
            w0_q    <= '0;
            w1_q    <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        vsid_q  <= seg_vsid;
                        pidx_q  <= ea_i[ADDR_W-SEG_BITS-1 -: PIDX_W];
                        off_q   <= ea_i[PAGE_BITS-1:0];
                        store_q <= store_i;
                        sec_q   <= 1'b0;
                        idx_q   <= '0;
                        hit_q   <= 1'b0;
                    end
                end
                ST_READ_TAG: begin
                    if (rd_ack_i) begin
                        w0_q <= rd_data_i;
                        if (tag_match) begin
                            hit_q <= 1'b1;
                        end else if (idx_q == LAST_IDX) begin
                            // R7: fall back to the secondary group
                            if (!sec_q) begin
                                sec_q <= 1'b1;
                                idx_q <= '0;
                            end
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                ST_READ_DATA: begin
                    if (rd_ack_i) w1_q <= rd_data_i;
                end
                default: ;
            endcase
        end
    end

    // ------------------------------------------------------------------
    // outputs
    // ------------------------------------------------------------------
    always_comb begin
        busy_o    = 1'b1;
        done_o    = 1'b0;
        found_o   = 1'b0;
        miss_o    = 1'b0;
        rd_req_o  = 1'b0;
        rd_addr_o = entry_addr;
        wr_req_o  = 1'b0;
        wr_addr_o = entry_addr + ADDR_W'(REF_BYTE_OFF);
        wr_byte_o = w1_q[15:8] | REF_SET_MASK;
        unique case (st_q)
            ST_IDLE: busy_o = 1'b0;
            ST_READ_TAG: rd_req_o = 1'b1;
            ST_READ_DATA: begin
                rd_req_o  = 1'b1;
                rd_addr_o = entry_addr + ADDR_W'(DATA_WORD_OFF);
            end
            ST_SET_REF: wr_req_o = 1'b1;
            ST_SET_CHG: begin
                wr_req_o  = 1'b1;
                wr_addr_o = entry_addr + ADDR_W'(CHG_BYTE_OFF);
                wr_byte_o = w1_q[7:0] | CHG_SET_MASK;
            end
            ST_FINISH: begin
                done_o  = 1'b1;
                found_o = hit_q;
                miss_o  = !hit_q;
            end
            default: busy_o = 1'b0;
        endcase
    end

    assign real_addr_o  = {w1_q[ADDR_W-1:PAGE_BITS], off_q};
    assign entry_w0_o   = w0_q;
    assign entry_w1_o   = w1_q;
    assign entry_addr_o = entry_addr;

endmodule

// File: rtl/hpt_walker_checker.sv
module hpt_walker_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              found_o,
    input logic              miss_o,
    input logic              rd_req_o,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              rd_ack_i,
    input logic              wr_req_o,
    input logic [ADDR_W-1:0] wr_addr_o,
    input logic [7:0]        wr_byte_o,
    input logic              wr_ack_i
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!rd_req_o && !wr_req_o));

    p_busy_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    p_done_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    p_done_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!busy_o && !done_o));

    p_word_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> (rd_addr_o[1:0] == 2'b00));

    p_result_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (found_o != miss_o));

    p_ref_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && !wr_addr_o[0]) |-> (wr_byte_o[0] && wr_addr_o[2:1] == 2'b11));

    p_chg_byte_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && wr_addr_o[0]) |-> (wr_byte_o[7] && wr_addr_o[2:1] == 2'b11));

    p_one_port_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req_o && wr_req_o));

    p_rd_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));

    p_wr_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && !wr_ack_i) |=> (wr_req_o && $stable(wr_addr_o) && $stable(wr_byte_o)));

endmodule

bind hpt_walker hpt_walker_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .found_o   (found_o),
    .miss_o    (miss_o),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .rd_ack_i  (rd_ack_i),
    .wr_req_o  (wr_req_o),
    .wr_addr_o (wr_addr_o),
    .wr_byte_o (wr_byte_o),
    .wr_ack_i  (wr_ack_i)
);

// File: tb/hpt_walker_bench.sv
module hpt_walker_bench;

    localparam logic [31:0] BASE = 32'h0010_0000;
    localparam logic [31:0] MASK = 32'h0000_FFC0;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        seg_wr_en;
    logic [3:0]  seg_wr_idx;
    logic [23:0] seg_wr_vsid;
    logic        start;
    logic [31:0] ea_drv;
    logic        st_drv;
    logic        busy_o, done_o, found_o, miss_o;
    logic [31:0] real_addr_o, entry_w0_o, entry_w1_o, entry_addr_o;
    logic        rd_req_o, rd_ack;
    logic [31:0] rd_addr_o, rd_data;
    logic        wr_req_o, wr_ack;
    logic [31:0] wr_addr_o;
    logic [7:0]  wr_byte_o;

    always #5 clk = ~clk;

    hpt_walker u_hpt_walker (
        .clk (clk), .rst_n (rst_n),
        .seg_wr_en_i (seg_wr_en), .seg_wr_idx_i (seg_wr_idx), .seg_wr_vsid_i (seg_wr_vsid),
        .tbl_base_i (BASE), .tbl_mask_i (MASK),
        .start_i (start), .ea_i (ea_drv), .store_i (st_drv),
        .busy_o (busy_o), .done_o (done_o), .found_o (found_o), .miss_o (miss_o),
        .real_addr_o (real_addr_o), .entry_w0_o (entry_w0_o), .entry_w1_o (entry_w1_o),
        .entry_addr_o (entry_addr_o),
        .rd_req_o (rd_req_o), .rd_addr_o (rd_addr_o), .rd_ack_i (rd_ack), .rd_data_i (rd_data),
        .wr_req_o (wr_req_o), .wr_addr_o (wr_addr_o), .wr_byte_o (wr_byte_o), .wr_ack_i (wr_ack)
    );

    int checks = 0;
    int errors = 0;

    // behavioural model state
    logic [31:0] mem [int unsigned];
    logic [23:0] segs [16];
    int unsigned exp_rd[$];
    int unsigned exp_wa[$];
    logic [7:0]  exp_wb[$];
    bit          exp_hit;
    logic [31:0] exp_real, exp_w0, exp_w1, exp_loc;
    int          n_rd, n_wr;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mrd(input logic [31:0] a);
        if (mem.exists(a >> 2)) return mem[a >> 2];
        return 32'h0;
    endfunction

    function automatic logic [31:0] grp(input logic [31:0] ea, input bit sec);
        logic [31:0] h;
        h = {8'h0, segs[ea[31:28]]} ^ {16'h0, ea[27:12]};
        if (sec) h = ~h;
        return (BASE & 32'hFFFF_FFC0) + ((h << 6) & MASK);
    endfunction

    function automatic logic [31:0] mk_w0(input bit v, input logic [23:0] vsid, input bit h, input logic [5:0] api);
        return {v, vsid, h, api};
    endfunction

    task automatic place(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1);
        mem[a >> 2]       = w0;
        mem[(a + 4) >> 2] = w1;
    endtask

    // walk the table behaviourally and queue the expected traffic
    task automatic predict(input logic [31:0] ea, input bit store);
        logic [23:0] vsid;
        logic [31:0] a, w0, w1;
        vsid = segs[ea[31:28]];
        exp_hit = 1'b0;
        for (int p = 0; p < 2 && !exp_hit; p++) begin
            for (int k = 0; k < 8 && !exp_hit; k++) begin
                a = grp(ea, p[0]) + 32'(k * 8);
                exp_rd.push_back(a);
                w0 = mrd(a);
                if (w0[31] == 1'b1 && w0[6] == p[0] && w0[30:7] == vsid && w0[5:0] == ea[27:22]) begin
                    exp_hit = 1'b1;
                    exp_rd.push_back(a + 4);
                    w1 = mrd(a + 4);
                    exp_w0 = w0; exp_w1 = w1; exp_loc = a;
                    exp_real = {w1[31:12], ea[11:0]};
                    if (!w1[8]) begin exp_wa.push_back(a + 6); exp_wb.push_back(w1[15:8] | 8'h01); end
                    if (!w1[7] && store) begin exp_wa.push_back(a + 7); exp_wb.push_back(w1[7:0] | 8'h80); end
                end
            end
        end
    endtask

    // memory responder: ack after a varying wait, compare every access
    initial begin
        int wait_cnt = 0;
        int lat = 1;
        rd_ack = 1'b0; wr_ack = 1'b0; rd_data = '0;
        forever begin
            @(negedge clk);
            if (rd_ack || wr_ack) begin
                rd_ack = 1'b0; wr_ack = 1'b0;
            end else if (rd_req_o || wr_req_o) begin
                if (wait_cnt >= lat) begin
                    wait_cnt = 0;
                    lat = (lat == 1) ? 2 : 1;
                    if (rd_req_o) begin
                        int unsigned e;
                        e = (exp_rd.size() > 0) ? exp_rd.pop_front() : 32'hFFFF_FFFF;
                        chk(rd_addr_o == e, rd_addr_o[2] ? "R4 second-word read address" : "R3 R6 R7 first-word read address",
                            rd_addr_o, e);
                        rd_data = mrd(rd_addr_o);
                        rd_ack = 1'b1;
                        n_rd++;
                    end else begin
                        int unsigned ea_w;
                        logic [7:0] eb;
                        logic [31:0] w;
                        int sh;
                        ea_w = (exp_wa.size() > 0) ? exp_wa.pop_front() : 32'hFFFF_FFFF;
                        eb   = (exp_wb.size() > 0) ? exp_wb.pop_front() : 8'h00;
                        chk(wr_addr_o == ea_w, "R10 R11 write address", wr_addr_o, ea_w);
                        chk(wr_byte_o == eb, "R10 R11 write byte", {24'h0, wr_byte_o}, {24'h0, eb});
                        w  = mrd(wr_addr_o & 32'hFFFF_FFFC);
                        sh = (3 - int'(wr_addr_o[1:0])) * 8;
                        w  = (w & ~(32'hFF << sh)) | (32'(wr_byte_o) << sh);
                        mem[wr_addr_o >> 2] = w;
                        wr_ack = 1'b1;
                        n_wr++;
                    end
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    task automatic seg_write(input logic [3:0] idx, input logic [23:0] v);
        @(negedge clk);
        seg_wr_en = 1'b1; seg_wr_idx = idx; seg_wr_vsid = v;
        segs[idx] = v;
        @(negedge clk);
        seg_wr_en = 1'b0;
    endtask

    task automatic run(input logic [31:0] ea, input bit store, input bit extra_start,
                       input bit want_hit, input int want_wr, input string name);
        bit busy_ok = 1'b1;
        int cyc = 0;
        predict(ea, store);
        chk(exp_hit == want_hit, {"R9 scenario intent ", name}, {31'h0, exp_hit}, {31'h0, want_hit});
        n_rd = 0; n_wr = 0;
        @(negedge clk);
        ea_drv = ea; st_drv = store; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done_o && cyc < 200) begin
            if (!busy_o) busy_ok = 1'b0;
            start = (extra_start && cyc == 3);
            if (start) ea_drv = ea ^ 32'h0F00_0000;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(busy_ok && busy_o && done_o, {"R2 busy held until done ", name}, {30'h0, busy_o, done_o}, 32'h3);
        chk(found_o == exp_hit, {"R9 found ", name}, {31'h0, found_o}, {31'h0, exp_hit});
        chk(miss_o == !exp_hit, {"R8 miss ", name}, {31'h0, miss_o}, {31'h0, !exp_hit});
        if (exp_hit) begin
            chk(real_addr_o == exp_real, {"R9 real address ", name}, real_addr_o, exp_real);
            chk(entry_w0_o == exp_w0, {"R9 first word ", name}, entry_w0_o, exp_w0);
            chk(entry_w1_o == exp_w1, {"R9 second word ", name}, entry_w1_o, exp_w1);
            chk(entry_addr_o == exp_loc, {"R9 entry address ", name}, entry_addr_o, exp_loc);
        end else begin
            chk(n_rd == 16, {"R8 sixteen reads on miss ", name}, n_rd, 16);
        end
        chk(exp_rd.size() == 0, {"R4 R6 reads all made ", name}, exp_rd.size(), 0);
        chk(exp_wa.size() == 0 && n_wr == want_wr, {"R10 R11 write count ", name}, n_wr, want_wr);
        @(negedge clk);
        chk(!busy_o && !done_o, {"R2 idle after done ", name}, {30'h0, busy_o, done_o}, 0);
        if (extra_start) begin
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                chk(!busy_o && !rd_req_o, "R2 start while busy ignored", {31'h0, busy_o}, 0);
            end
        end
        exp_rd.delete(); exp_wa.delete(); exp_wb.delete();
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired R2 actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] g, ea;
        rst_n = 1'b0; start = 1'b0; ea_drv = '0; st_drv = 1'b0;
        seg_wr_en = 1'b0; seg_wr_idx = '0; seg_wr_vsid = '0;
        for (int i = 0; i < 16; i++) segs[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!busy_o && !done_o && !found_o && !miss_o && !rd_req_o && !wr_req_o,
            "R1 reset outputs", {26'h0, busy_o, done_o, found_o, miss_o, rd_req_o, wr_req_o}, 0);

        // R5 R6 R10 R11: primary hit at slot 3, store, both status bits clear
        seg_write(4'h1, 24'h000123);
        ea = 32'h1234_5678;
        g = grp(ea, 1'b0);
        place(g + 0,  mk_w0(1'b0, 24'h000123, 1'b0, ea[27:22]), 32'hDEAD_0000);
        place(g + 8,  mk_w0(1'b1, 24'h000123, 1'b1, ea[27:22]), 32'hDEAD_1000);
        place(g + 16, mk_w0(1'b1, 24'h000123, 1'b0, ea[27:22] ^ 6'h01), 32'hDEAD_2000);
        place(g + 24, mk_w0(1'b1, 24'h000123, 1'b0, ea[27:22]), 32'hABCD_E002);
        place(g + 40, mk_w0(1'b1, 24'h000123, 1'b0, ea[27:22]), 32'h7777_7000);
        run(ea, 1'b1, 1'b0, 1'b1, 2, "primary store");
        chk(mrd(g + 28) == 32'hABCD_E182, "R10 R11 bits set in memory", mrd(g + 28), 32'hABCD_E182);

        // status bits now set: no writes
        run(ea, 1'b0, 1'b0, 1'b1, 0, "primary load bits set");

        // R11: load with both bits clear writes only the referenced byte
        seg_write(4'h2, 24'h00BEEF);
        ea = 32'h2000_1ABC;
        g = grp(ea, 1'b0);
        place(g, mk_w0(1'b1, 24'h00BEEF, 1'b0, ea[27:22]), 32'h5555_5000);
        run(ea, 1'b0, 1'b0, 1'b1, 1, "load ref only");
        chk(mrd(g + 4) == 32'h5555_5100, "R11 load leaves changed bit clear", mrd(g + 4), 32'h5555_5100);

        // R7: secondary hit, wrong-pass entries skipped
        seg_write(4'h3, 24'h0F0F0F);
        ea = 32'h3ABC_D123;
        place(grp(ea, 1'b0) + 16, mk_w0(1'b1, 24'h0F0F0F, 1'b1, ea[27:22]), 32'h0);
        place(grp(ea, 1'b1) + 16, mk_w0(1'b1, 24'h0F0F0F, 1'b0, ea[27:22]), 32'h0);
        place(grp(ea, 1'b1) + 48, mk_w0(1'b1, 24'h0F0F0F, 1'b1, ea[27:22]), 32'h1234_5180);
        run(ea, 1'b1, 1'b0, 1'b1, 0, "secondary hit");

        // R8: full miss
        seg_write(4'h4, 24'h000777);
        run(32'h4111_1000, 1'b1, 1'b0, 1'b0, 0, "full miss");

        // R12: segment selection by top address bits
        seg_write(4'h5, 24'h0000AA);
        seg_write(4'h6, 24'h0000BB);
        ea = 32'h6222_2000;
        place(grp(ea, 1'b0), mk_w0(1'b1, 24'h0000BB, 1'b0, ea[27:22]), 32'h0BAD_0100);
        run(32'h5222_2000, 1'b1, 1'b0, 1'b0, 0, "R12 other segment misses");
        run(ea, 1'b1, 1'b0, 1'b1, 1, "R12 selected segment hits");

        // R2: start pulse during a walk is ignored
        run(32'h4111_1000, 1'b0, 1'b1, 1'b0, 0, "start while busy");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule